// File: doc/BRIEF.md
# Peripheral DMA Transfer Counter

This block lives inside a peripheral and governs how its 16-entry data FIFO is emptied or filled by an outside DMA agent. A host programs a 16-bit byte count through a small register port, then issues a command. When bit 7 of the command byte is set, the stored count is copied into a separate live down-counter and the block starts requesting service on `dreq`, based on FIFO occupancy and the direction chosen by bit 0 of the same command. Every accepted acknowledge moves one byte and lowers the live count by one. When the count reaches zero the request is withdrawn and an interrupt is raised.

A plain byte source (read direction) or byte sink (write direction) stands in for the peripheral's far-side bus. Misuse is reported through three sticky status bits: an acknowledge that arrives while the register port is selected, a new command that cuts off a transfer before its count was met, and normal completion. Reading the status register clears them.

Top module: `dma_xfer_engine`

## Requirements
- R1: The stored count is written as two bytes (address 0 low, address 1 high) and reaches the live counter only when a command with bit 7 set is written to address 2; reads of addresses 0 and 1 return the live counter's low and high byte, and a read of address 2 returns {active, direction, live counter bit 16} in bits 2..0.
- R2: A command with bit 7 clear loads nothing, ends any running transfer and keeps `dreq` low; only its direction bit takes effect.
- R3: A stored count of zero loads the live counter with 65536.
- R4: An acknowledge is accepted when `dack` is high, `cs` is low and `dreq` is high in the same cycle; each accepted acknowledge lowers the live count by one and moves one byte (`dma_rdata` shows the FIFO head in read direction; `dma_wdata` is stored in write direction).
- R5: Command bit 0 = 1 selects read direction (far side fills, DMA drains), 0 selects write direction; `dreq` is high only while a transfer is active and the FIFO is non-empty (read) or not full at 16 entries (write).
- R6: The acknowledge that takes the live count to zero makes `dreq` low and `irq` high from the next cycle, and sets status bit 0.
- R7: `dack` high while `cs` is high sets status bit 2 and neither changes the live count nor moves a byte.
- R8: A command written while a transfer is still active sets status bit 1; the new command then takes effect.
- R9: A read of address 3 returns the status bits {illegal, count error, done} in bits 2..0 and clears them after the read, except that an event in the same cycle stays set; `irq` is high whenever any status bit is set.
- R10: In read direction `src_ready` is high while the FIFO is not full; in write direction `snk_valid` is high while it is non-empty with the oldest byte on `snk_data`; bytes leave in arrival order.
- R11: After reset `dreq` and `irq` are low, stored and live counts, status and direction (write) are zero, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Register port select |
| wr | input | 1 | Register write strobe (with `cs`) |
| rd | input | 1 | Register read strobe (with `cs`) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational, zero when not reading |
| dreq | output | 1 | Service request to the DMA agent |
| dack | input | 1 | One-cycle acknowledge from the DMA agent |
| dma_wdata | input | 8 | Byte from the DMA agent (write direction) |
| dma_rdata | output | 8 | Byte to the DMA agent (read direction) |
| irq | output | 1 | Interrupt, any status bit set |
| src_valid | input | 1 | Far-side byte available (read direction) |
| src_data | input | 8 | Far-side byte |
| src_ready | output | 1 | FIFO can take a far-side byte |
| snk_valid | output | 1 | FIFO byte available for the far side (write direction) |
| snk_data | output | 8 | Oldest FIFO byte |
| snk_ready | input | 1 | Far side takes the byte |

## Verification
The assertions assume the DMA agent pulses `dack` for one cycle per byte and that the far side only pushes while `src_ready` is high and only pops while `snk_valid` is high; the FIFO overflow and underflow checks depend on this. The stimulus holds `src_valid` and `snk_ready` only when the block allows it, and deliberately breaks the port rule only for the `dack`-with-`cs` case, which the block must absorb. Acknowledges are also sent while `dreq` is low, which the block must ignore.

// File: rtl/dxe_pkg.sv
// Shared constants for the DMA transfer counter.
// Assumes an 8-bit register port with a 2-bit address.
package dxe_pkg;

    typedef enum logic [1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CMD    = 2'd2,
        REG_STAT   = 2'd3
    } reg_addr_e;

    localparam int CMD_DMA_BIT = 7;
    localparam int CMD_DIR_BIT = 0;

    localparam int ST_DONE = 0;
    localparam int ST_CERR = 1;
    localparam int ST_ILL  = 2;
    localparam int ST_W    = 3;

endpackage

// File: rtl/dxe_fifo.sv
// Data FIFO between the DMA agent and the far side.
// Assumes callers never push when full nor pop when empty.
// Output dout is the oldest entry (meaningful only when not empty).
module dxe_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam bit POW2 = ((1 << AW) == DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0]     fill;

    // pointer advance: natural wrap for power-of-two depths, compare otherwise
    generate
        if (POW2) begin : g_wrap_pow2
            assign wr_nxt = wr_ptr + AW'(1);
            assign rd_nxt = rd_ptr + AW'(1);
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    endgenerate

    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);
    assign dout  = mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
            case ({push, pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R10

endmodule

// File: rtl/dxe_counter.sv
// Stored count register plus live down-counter.
// load copies the stored count (zero means 2**CNT_W); stop ends the
// transfer without touching the count; ack is an already-qualified handshake.
// Assumes CNT_W = 2*DATA_W for the two byte-wide writes.
module dxe_counter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    input  logic              stop,
    input  logic              ack,
    output logic [CNT_W:0]    live,
    output logic              active,
    output logic              done_evt
);
    localparam int LIVE_W = CNT_W + 1;
    localparam int HI_W   = CNT_W - DATA_W;

    logic [CNT_W-1:0] stored;

    assign done_evt = ack && active && (live == LIVE_W'(1));

    // stored count: byte-wise host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else begin
            if (we_lo) stored[DATA_W-1:0]     <= wdata;
            if (we_hi) stored[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        end
    end

    // live counter and active flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live   <= '0;
            active <= 1'b0;
        end else if (load) begin
            live   <= (stored == '0) ? (LIVE_W'(1) << CNT_W) : {1'b0, stored};
            active <= 1'b1;
        end else if (stop) begin
            active <= 1'b0;
        end else if (ack && active) begin
            live <= live - LIVE_W'(1);
            if (live == LIVE_W'(1)) active <= 1'b0;
        end
    end

    AST_ACK_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && active && !load && !stop) |=> (live == $past(live) - LIVE_W'(1))); // R4
    AST_ZERO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (load && stored == '0) |=> (live == (LIVE_W'(1) << CNT_W))); // R3
    AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !ack) |=> $stable(live)); // R1

endmodule

// File: rtl/dxe_status.sv
// Sticky interrupt status. A set in the same cycle as a clear wins.
// irq is high while any bit is held.
module dxe_status #(
    parameter int NBITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set,
    input  logic             clr,
    output logic [NBITS-1:0] bits,
    output logic             irq
);
    assign irq = |bits;

    // hold, clear on read, set on event
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= (clr ? '0 : bits) | set;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq); // R9

endmodule

// File: rtl/dma_xfer_engine.sv
// Peripheral-side DMA transfer counter: register decode, direction,
// request generation and handshake qualification around the FIFO,
// counter and status blocks. Assumes dack is a one-cycle pulse per byte.
module dma_xfer_engine #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              dreq,
    input  logic              dack,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              irq,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data,
    input  logic              snk_ready
);
    import dxe_pkg::*;

    logic              wr_sel, rd_sel, cmd_we, dma_cmd, pio_cmd;
    logic              dir_rd, acc, illegal;
    logic              f_push, f_pop, f_full, f_empty;
    logic [DATA_W-1:0] f_din, f_dout;
    logic [CNT_W:0]    live;
    logic              active, done_evt;
    logic [ST_W-1:0]   st_set, st_bits;

    assign wr_sel  = cs && wr;
    assign rd_sel  = cs && rd;
    assign cmd_we  = wr_sel && (addr == REG_CMD);
    assign dma_cmd = cmd_we &&  wdata[CMD_DMA_BIT];
    assign pio_cmd = cmd_we && !wdata[CMD_DMA_BIT];

    // request and handshake qualification
    assign dreq    = active && (dir_rd ? !f_empty : !f_full);
    assign acc     = dack && !cs && dreq;
    assign illegal = dack && cs;

    // FIFO steering by direction
    assign f_push = dir_rd ? (src_valid && !f_full) : acc;
    assign f_din  = dir_rd ? src_data : dma_wdata;
    assign f_pop  = dir_rd ? acc : (snk_ready && !f_empty);

    assign src_ready = dir_rd && !f_full;
    assign snk_valid = !dir_rd && !f_empty;
    assign snk_data  = f_dout;
    assign dma_rdata = f_dout;

    // direction latched from every command
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_rd <= 1'b0;
        else if (cmd_we) dir_rd <= wdata[CMD_DIR_BIT];
    end

    always_comb begin
        st_set          = '0;
        st_set[ST_DONE] = done_evt;
        st_set[ST_CERR] = cmd_we && active;
        st_set[ST_ILL]  = illegal;
    end

    // register read mux
    always_comb begin
        rdata = '0;
        if (rd_sel) begin
            case (addr)
                REG_CNT_LO: rdata = live[DATA_W-1:0];
                REG_CNT_HI: rdata = DATA_W'(live[CNT_W-1:DATA_W]);
                REG_CMD:    rdata = DATA_W'({active, dir_rd, live[CNT_W]});
                default:    rdata = DATA_W'(st_bits);
            endcase
        end
    end

    dxe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(f_push), .din(f_din), .pop(f_pop),
        .dout(f_dout), .full(f_full), .empty(f_empty)
    );

    dxe_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .we_lo(wr_sel && addr == REG_CNT_LO),
        .we_hi(wr_sel && addr == REG_CNT_HI),
        .wdata(wdata), .load(dma_cmd), .stop(pio_cmd), .ack(acc),
        .live(live), .active(active), .done_evt(done_evt)
    );

    dxe_status #(.NBITS(ST_W)) u_st (
        .clk(clk), .rst_n(rst_n), .set(st_set),
        .clr(rd_sel && addr == REG_STAT), .bits(st_bits), .irq(irq)
    );

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && cs && !cmd_we) |=> ($stable(live) && st_bits[ST_ILL])); // R7
    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && live == (CNT_W+1)'(1)) |=> (!dreq && irq)); // R6
    AST_PIO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pio_cmd |=> !dreq); // R2
    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && active) |=> st_bits[ST_CERR]); // R8

endmodule

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs, wr, rd, dack, src_valid, snk_ready;
    logic [1:0] addr;
    logic [7:0] wdata, dma_wdata, src_data;
    logic [7:0] rdata, dma_rdata, snk_data;
    logic       dreq, irq, src_ready, snk_valid;

    always #10 clk = ~clk;

    dma_xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dreq(dreq), .dack(dack),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .irq(irq),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference
    int         m_cnt, m_stored;
    bit         m_act, m_dir;
    bit [2:0]   m_st;
    logic [7:0] m_q[$];
    logic [7:0] last_rd;

    function automatic bit m_dreq();
        return m_act && (m_dir ? (m_q.size() > 0) : (m_q.size() < 16));
    endfunction

    function automatic logic [7:0] m_rdata();
        if (!(cs && rd)) return 8'h00;
        case (addr)
            2'd0: return m_cnt[7:0];
            2'd1: return m_cnt[15:8];
            2'd2: return {5'b0, m_act, m_dir, m_cnt[16]};
            default: return {5'b0, m_st};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R5 dreq", dreq, m_dreq());
        chk("R9 irq", irq, |m_st);
        chk("R10 src_ready", src_ready, m_dir && m_q.size() < 16);
        chk("R10 snk_valid", snk_valid, !m_dir && m_q.size() > 0);
        if (!m_dir && m_q.size() > 0) chk("R10 snk_data", snk_data, m_q[0]);
        if (m_dir && m_q.size() > 0)  chk("R4 dma_rdata", dma_rdata, m_q[0]);
        if (cs && rd) chk("R1 rdata", rdata, m_rdata());
        last_rd = rdata;
    endtask

    task automatic m_update();
        bit dq, acc, ill, cmdw, full, empty;
        dq = m_dreq();
        full = (m_q.size() == 16);
        empty = (m_q.size() == 0);
        acc = dack && !cs && dq;
        ill = dack && cs;
        cmdw = cs && wr && addr == 2'd2;
        if (cs && rd && addr == 2'd3) m_st = 3'b000;
        if (ill) m_st[2] = 1'b1;
        if (cmdw && m_act) m_st[1] = 1'b1;
        if (m_dir) begin
            if (acc) void'(m_q.pop_front());
            if (src_valid && !full) m_q.push_back(src_data);
        end else begin
            if (snk_ready && !empty) void'(m_q.pop_front());
            if (acc) m_q.push_back(dma_wdata);
        end
        if (cmdw && wdata[7]) begin
            m_cnt = (m_stored == 0) ? 65536 : m_stored;
            m_act = 1'b1;
        end else if (cmdw) begin
            m_act = 1'b0;
        end else if (acc) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                m_act = 1'b0;
                m_st[0] = 1'b1;
            end
        end
        if (cs && wr && addr == 2'd0) m_stored = {m_stored[15:8], wdata};
        if (cs && wr && addr == 2'd1) m_stored = {wdata, m_stored[7:0]};
        if (cmdw) m_dir = wdata[0];
        if (!rst_n) begin
            m_cnt = 0; m_stored = 0; m_act = 0; m_dir = 0; m_st = 0;
            m_q.delete();
        end
    endtask

    // one clock: inputs already driven after a falling edge
    task automatic cyc();
        #1 compare();
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic idle_in();
        cs = 0; wr = 0; rd = 0; addr = 0; wdata = 0; dack = 0;
        dma_wdata = 0; src_valid = 0; src_data = 0; snk_ready = 0;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        idle_in(); cs = 1; wr = 1; addr = a; wdata = d; cyc(); idle_in();
    endtask

    task automatic reg_rd(input logic [1:0] a);
        idle_in(); cs = 1; rd = 1; addr = a; cyc(); idle_in();
    endtask

    task automatic ack(input logic [7:0] d);
        idle_in(); dack = 1; dma_wdata = d; cyc(); idle_in();
    endtask

    task automatic src_push(input logic [7:0] d);
        idle_in(); src_valid = 1; src_data = d; cyc(); idle_in();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_in();
        rst_n = 0;
        m_update();
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R11: reset state through ports
        chk("R11 dreq", dreq, 0);
        chk("R11 irq", irq, 0);
        for (int a = 0; a < 4; a++) begin
            reg_rd(a[1:0]);
            chk("R11 reg", last_rd, 0);
        end

        // R1: stored count does not reach the live counter before a command
        reg_wr(2'd0, 8'h05);
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd0);
        chk("R1 live before load", last_rd, 8'h00);
        reg_wr(2'd2, 8'h81);            // DMA, read direction
        reg_rd(2'd0);
        chk("R1 live after load", last_rd, 8'h05);
        chk("R5 dreq empty fifo", dreq, 0);
        ack(8'h00);                     // ignored: dreq low
        reg_rd(2'd0);
        chk("R4 ack without dreq ignored", last_rd, 8'h05);
        for (int i = 0; i < 3; i++) src_push(8'hA0 + 8'(i));
        chk("R5 dreq nonempty", dreq, 1);
        for (int i = 0; i < 3; i++) ack(8'h00);
        chk("R5 dreq drained", dreq, 0);
        src_push(8'hB0);
        src_push(8'hB1);
        ack(8'h00);
        chk("R6 one left", irq, 0);
        ack(8'h00);
        chk("R6 dreq after zero", dreq, 0);
        chk("R6 irq after zero", irq, 1);
        reg_rd(2'd3);
        chk("R9 status done", last_rd, 8'h01);
        reg_rd(2'd3);
        chk("R9 status cleared", last_rd, 8'h00);
        chk("R9 irq cleared", irq, 0);

        // R5/R10: write direction fills to 16 then drains in order
        reg_wr(2'd0, 8'd20);
        reg_wr(2'd2, 8'h80);
        for (int i = 0; i < 16; i++) ack(8'h40 + 8'(i));
        chk("R5 dreq full", dreq, 0);
        ack(8'hEE);                     // ignored while full
        reg_rd(2'd0);
        chk("R4 count at full", last_rd, 8'd4);
        for (int i = 0; i < 16; i++) begin
            idle_in(); snk_ready = 1; cyc(); idle_in();
        end
        chk("R10 drained", snk_valid, 0);

        // R7: dack together with cs
        idle_in(); cs = 1; rd = 1; addr = 2'd0; dack = 1; cyc(); idle_in();
        reg_rd(2'd0);
        chk("R7 count held", last_rd, 8'd4);
        chk("R7 irq", irq, 1);
        // R9: event in the read cycle survives the clear
        idle_in(); cs = 1; rd = 1; addr = 2'd3; dack = 1; cyc(); idle_in();
        chk("R9 read value", last_rd, 8'h04);
        reg_rd(2'd3);
        chk("R9 same-cycle set kept", last_rd, 8'h04);

        // R8 + R2: PIO command aborts active transfer
        ack(8'h11);
        reg_wr(2'd2, 8'h01);
        chk("R2 dreq low", dreq, 0);
        reg_rd(2'd0);
        chk("R2 count untouched", last_rd, 8'd3);
        reg_rd(2'd3);
        chk("R8 count error", last_rd, 8'h02);
        src_push(8'hC3);
        chk("R2 dreq with data", dreq, 0);

        // R3: zero count means 65536
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd2, 8'h80);
        reg_rd(2'd2);
        chk("R3 bit16", last_rd, 8'h05);
        for (int i = 0; i < 3; i++) ack(8'h70 + 8'(i));
        reg_rd(2'd0);
        chk("R3 low", last_rd, 8'hFD);
        reg_rd(2'd1);
        chk("R3 high", last_rd, 8'hFF);
        reg_wr(2'd2, 8'h81);            // DMA cmd over active: R8
        reg_rd(2'd3);
        chk("R8 dma over dma", last_rd, 8'h02);
        repeat (4) cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule